// File: doc/BRIEF.md
# Slew-Limited Select-Driven Clock Synthesizer

This block makes a pair of related clocks from a fast system clock using a numerically controlled oscillator. A phase accumulator adds a tuning word on every system cycle, and its top bit is the double-rate output clock. A toggle stage divides that clock by two to form the CPU clock. A 3-bit select input chooses one of eight target frequencies. Their tuning words are computed at elaboration from the system clock rate and the accumulator width.

When the select changes, the oscillator does not jump to the new word. The word in use moves toward the chosen target one small step at a time. It updates only once per double-rate period, at a rising edge, and each step is at most about one part in 1024 of the current word. This bounds the change in period from one cycle to the next, so a wide frequency change takes thousands of output periods. The block suits a processor clock that has to be slowed or sped up without breaking cycle-to-cycle timing limits. The word in use is exposed on a port so that the ramp can be observed.

Top module: `slew_clk_synth`

## Requirements
- R1: With the default parameters (24-bit accumulator, 400,000 kHz system clock), select code c gives the target word floor(f_c * 2^24 / 400000). f_c in kHz is 7580, 15511, 59875, 40090, 50113, 66476, 79772 and 100226 for codes 0 to 7. A settled output produces one double-rate rising edge per 2^24 / word system cycles, within one edge over the observed window.
- R2: A synchronous reset (rst high) loads the target word of the present select at once, with no ramp. It clears the accumulator, so both clock outputs read 0 when reset ends. The first double-rate high appears ceil(2^23 / word) cycles after that.
- R3: The word in use changes only on the system cycle that follows a low-to-high change of the double-rate output.
- R4: Each update moves the word toward the current target by at most max(word >> 10, 1) and never past the target.
- R5: Once the word equals the target of the select in force, it stays unchanged for as long as the select stays unchanged.
- R6: A select change during a ramp carries on from the word already reached, with no restart and no jump. The word then settles exactly on the new target.
- R7: The double-rate output is glitch-free. Every high phase and every low phase lasts 2^23 / word system cycles, within one cycle, both during a ramp and at rest.
- R8: The CPU clock toggles exactly on the cycle after each double-rate rising edge and at no other time. It therefore runs at half the double-rate frequency.
- R9: A change from code 0 to code 7 finishes through more than 1000 separate updates and ends exactly on the code-7 word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that drives the accumulator |
| rst | input | 1 | Synchronous reset, active high |
| freq_sel | input | 3 | Frequency select code |
| clk2x_o | output | 1 | Double-rate clock (top bit of the accumulator) |
| cpu_clk_o | output | 1 | CPU clock, half the rate of clk2x_o |
| cur_word_o | output | ACC_W | Tuning word in use |

## Verification
The properties assume that reset is asserted from the first clock edge and is held for at least two cycles. They also assume that freq_sel is stable around each rising edge, although any code may follow any other. The stimulus changes freq_sel and rst one time unit after a rising edge, and keeps the select steady through every reset release. Wide, narrow and reversed ramps are all driven this way, and so is a retarget in the middle of a ramp, so the step and overshoot properties see steps going both up and down.

// File: rtl/slewclk_pkg.sv
`timescale 1ns/1ps
package slewclk_pkg;
  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;

  typedef logic [SEL_W-1:0] sel_t;

  // Target double-rate frequency per select code, in kHz
  function automatic longint unsigned code_khz(input int unsigned code);
    case (code)
      0:       return 64'd7580;
      1:       return 64'd15511;
      2:       return 64'd59875;
      3:       return 64'd40090;
      4:       return 64'd50113;
      5:       return 64'd66476;
      6:       return 64'd79772;
      7:       return 64'd100226;
      default: return 64'd0;
    endcase
  endfunction

  // Accumulator increment that yields code_khz(code) at sys_khz
  function automatic longint unsigned word_for(input int unsigned code,
                                               input int unsigned acc_w,
                                               input longint unsigned sys_khz);
    return (code_khz(code) << acc_w) / sys_khz;
  endfunction
endpackage

// File: rtl/slew_tgt_rom.sv
`timescale 1ns/1ps
module slew_tgt_rom import slewclk_pkg::*; #(
  parameter int          ACC_W   = 24,
  parameter longint      SYS_KHZ = 400000
) (
  input  sel_t             sel_i,
  output logic [ACC_W-1:0] tgt_o
);
  logic [ACC_W-1:0] words [NUM_SEL];

  // One constant entry per select code, computed at elaboration
  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_entry
    assign words[gi] = ACC_W'(word_for(gi, ACC_W, SYS_KHZ));
  end

  assign tgt_o = words[sel_i];
endmodule

// File: rtl/slew_word_step.sv
`timescale 1ns/1ps
module slew_word_step #(
  parameter int ACC_W      = 24,
  parameter int STEP_SHIFT = 10
) (
  input  logic [ACC_W-1:0] cur_i,
  input  logic [ACC_W-1:0] tgt_i,
  output logic [ACC_W-1:0] nxt_o
);
  localparam logic [ACC_W-1:0] MIN_STEP = ACC_W'(1);

  logic [ACC_W-1:0] step_raw, step, gap_up, gap_dn;

  assign step_raw = cur_i >> STEP_SHIFT;
  assign step     = (step_raw == '0) ? MIN_STEP : step_raw;
  assign gap_up   = tgt_i - cur_i;
  assign gap_dn   = cur_i - tgt_i;

  always_comb begin
    if (cur_i < tgt_i)
      nxt_o = (gap_up <= step) ? tgt_i : cur_i + step;
    else if (cur_i > tgt_i)
      nxt_o = (gap_dn <= step) ? tgt_i : cur_i - step;
    else
      nxt_o = cur_i;
  end
endmodule

// File: rtl/slew_phase_nco.sv
`timescale 1ns/1ps
module slew_phase_nco #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] word_i,
  output logic             clk2x_o,
  output logic             cpu_o,
  output logic             rise_o
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc_q;
  logic             msb_d_q;
  logic             div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      msb_d_q <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      acc_q   <= acc_q + word_i;
      msb_d_q <= acc_q[MSB];
      if (rise_o) div_q <= ~div_q;
    end
  end

  assign rise_o  = acc_q[MSB] & ~msb_d_q;
  assign clk2x_o = acc_q[MSB];
  assign cpu_o   = div_q;
endmodule

// File: rtl/slew_clk_synth.sv
`timescale 1ns/1ps
module slew_clk_synth import slewclk_pkg::*; #(
  parameter int     ACC_W      = 24,
  parameter longint SYS_KHZ    = 400000,
  parameter int     STEP_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] freq_sel,
  output logic             clk2x_o,
  output logic             cpu_clk_o,
  output logic [ACC_W-1:0] cur_word_o
);
  logic [ACC_W-1:0] tgt_word;
  logic [ACC_W-1:0] nxt_word;
  logic [ACC_W-1:0] word_q;
  logic             rise;

  slew_tgt_rom #(.ACC_W(ACC_W), .SYS_KHZ(SYS_KHZ)) u_rom (
    .sel_i (freq_sel),
    .tgt_o (tgt_word)
  );

  slew_word_step #(.ACC_W(ACC_W), .STEP_SHIFT(STEP_SHIFT)) u_step (
    .cur_i (word_q),
    .tgt_i (tgt_word),
    .nxt_o (nxt_word)
  );

  // Word in use: loaded directly on reset, stepped once per output period
  always_ff @(posedge clk) begin
    if (rst)       word_q <= tgt_word;
    else if (rise) word_q <= nxt_word;
  end

  slew_phase_nco #(.ACC_W(ACC_W)) u_nco (
    .clk     (clk),
    .rst     (rst),
    .word_i  (word_q),
    .clk2x_o (clk2x_o),
    .cpu_o   (cpu_clk_o),
    .rise_o  (rise)
  );

  assign cur_word_o = word_q;
endmodule

// File: rtl/slew_clk_synth_chk.sv
`timescale 1ns/1ps
module slew_clk_synth_chk #(
  parameter int ACC_W      = 24,
  parameter int STEP_SHIFT = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             clk2x,
  input logic             cpu_clk,
  input logic [ACC_W-1:0] cur_word,
  input logic [ACC_W-1:0] tgt_word
);
  logic [ACC_W-1:0] prev_q;
  logic [ACC_W-1:0] lim, delta;

  always_ff @(posedge clk) prev_q <= cur_word;

  assign lim   = ((prev_q >> STEP_SHIFT) == '0) ? ACC_W'(1) : (prev_q >> STEP_SHIFT);
  assign delta = (cur_word >= prev_q) ? cur_word - prev_q : prev_q - cur_word;

  // R3
  word_moves_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_word != $past(cur_word)) |-> ($past(clk2x) && !$past(clk2x, 2)));

  // R4
  step_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
    delta <= lim);

  // R4
  rise_no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cur_word) < $past(tgt_word)) |->
      (cur_word >= $past(cur_word) && cur_word <= $past(tgt_word)));

  // R4
  fall_no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cur_word) > $past(tgt_word)) |->
      (cur_word <= $past(cur_word) && cur_word >= $past(tgt_word)));

  // R5
  hold_on_target_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cur_word) == $past(tgt_word)) |-> $stable(cur_word));

  // R8
  cpu_follows_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_clk) != cpu_clk) == ($past(clk2x) && !$past(clk2x, 2)));
endmodule

bind slew_clk_synth slew_clk_synth_chk #(.ACC_W(ACC_W), .STEP_SHIFT(STEP_SHIFT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk2x    (clk2x_o),
  .cpu_clk  (cpu_clk_o),
  .cur_word (cur_word_o),
  .tgt_word (tgt_word)
);

// File: tb/tb_slew_clk_synth.sv
`timescale 1ns/1ps
module tb_slew_clk_synth;
  localparam int     W    = 24;
  localparam longint SYS  = 400000;
  localparam longint HALF = 64'd1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   sel = 3'd0;
  logic         clk2x, cpu;
  logic [W-1:0] word;

  always #5 clk = ~clk;

  slew_clk_synth dut (
    .clk(clk), .rst(rst), .freq_sel(sel),
    .clk2x_o(clk2x), .cpu_clk_o(cpu), .cur_word_o(word)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  function automatic longint exp_word(input int c);
    longint k;
    case (c)
      0: k = 7580;   1: k = 15511;  2: k = 59875;  3: k = 40090;
      4: k = 50113;  5: k = 66476;  6: k = 79772;  default: k = 100226;
    endcase
    return (k << W) / SYS;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle monitor, sampled at the falling edge
  bit mon_on = 0, mon_fresh = 0, skip_run = 0;
  logic pc1, pc2, pcpu;
  logic [W-1:0] pw;
  logic [2:0] psel;
  int run_len;
  int r3_bad, r4_bad, r5_bad, r7_bad, r8_bad, upd_cnt, rise_cnt, cpu_rise_cnt;

  task automatic clear_counts();
    r3_bad = 0; r4_bad = 0; r5_bad = 0; r7_bad = 0; r8_bad = 0;
    upd_cnt = 0; rise_cnt = 0; cpu_rise_cnt = 0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (mon_fresh) begin
        mon_fresh = 0; skip_run = 1; run_len = 1;
        pc2 = clk2x;
      end else begin
        if (word != pw) begin
          longint lim, d, t;
          upd_cnt++;
          if (!(pc1 && !pc2)) r3_bad++;
          lim = longint'(pw) >> 10;
          if (lim == 0) lim = 1;
          d = (word > pw) ? longint'(word) - longint'(pw) : longint'(pw) - longint'(word);
          if (d > lim) r4_bad++;
          t = exp_word(psel);
          if (pw < t && (word < pw || word > t)) r4_bad++;
          if (pw > t && (word > pw || word < t)) r4_bad++;
          if (longint'(pw) == t) r5_bad++;
        end
        if ((cpu != pcpu) != (pc1 && !pc2)) r8_bad++;
        if (clk2x && !pc1) rise_cnt++;
        if (cpu && !pcpu) cpu_rise_cnt++;
        if (clk2x != pc1) begin
          if (!skip_run) begin
            longint e;
            e = longint'(run_len) * longint'(word) - HALF;
            if (e < 0) e = -e;
            if (e > 2 * longint'(word)) r7_bad++;
          end
          skip_run = 0;
          run_len = 1;
        end else begin
          run_len++;
        end
        pc2 = pc1;
      end
      pc1 = clk2x; pcpu = cpu; pw = word; psel = sel;
    end
  end

  task automatic set_sel(input int s);
    @(posedge clk); #1 sel = 3'(s);
  endtask

  // Reset with code s, check the reset state (R1, R2) and start the monitor
  task automatic do_reset(input int s);
    mon_on = 0;
    @(posedge clk); #1 rst = 1'b1; sel = 3'(s);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    clear_counts();
    mon_fresh = 1; mon_on = 1;
    @(negedge clk);
    chk(longint'(word) == exp_word(s), "R1 reset word", word, exp_word(s));
    chk(clk2x == 1'b0 && cpu == 1'b0, "R2 outputs cleared", {clk2x, cpu}, 0);
  endtask

  task automatic t_reset_table();
    for (int c = 0; c < 8; c++) do_reset(c);
    for (int c = 0; c < 8; c += 7) begin
      int n;
      longint e;
      do_reset(c);
      e = (HALF + exp_word(c) - 1) / exp_word(c);
      n = 0;
      while (!clk2x && n < 1000) begin @(negedge clk); n++; end
      chk(n == e, "R2 first high after accumulator clear", n, e);
    end
  endtask

  task automatic t_settled();
    int codes [3] = '{1, 3, 6};
    foreach (codes[i]) begin
      longint er;
      do_reset(codes[i]);
      repeat (4000) @(negedge clk);
      er = (64'd4000 * exp_word(codes[i])) >> W;
      chk(rise_cnt >= er - 1 && rise_cnt <= er + 1, "R1 settled rate", rise_cnt, er);
      chk(cpu_rise_cnt >= rise_cnt / 2 - 1 && cpu_rise_cnt <= rise_cnt / 2 + 1,
          "R8 half rate", cpu_rise_cnt, rise_cnt / 2);
      chk(upd_cnt == 0 && longint'(word) == exp_word(codes[i]), "R5 hold settled", upd_cnt, 0);
      chk(r7_bad == 0, "R7 settled phases", r7_bad, 0);
    end
  endtask

  task automatic wait_word(input longint t, input int limit, output bit ok);
    int n = 0;
    ok = 0;
    while (n < limit) begin
      @(negedge clk); n++;
      if (longint'(word) == t) begin ok = 1; break; end
    end
  endtask

  task automatic t_wide_ramp();
    bit ok;
    logic [W-1:0] held;
    do_reset(0);
    set_sel(7);
    wait_word(exp_word(7), 120000, ok);
    chk(ok, "R9 reached top word", word, exp_word(7));
    chk(upd_cnt > 1000, "R9 many small updates", upd_cnt, 1001);
    chk(r3_bad == 0, "R3 update only after rise", r3_bad, 0);
    chk(r4_bad == 0, "R4 step bound and direction", r4_bad, 0);
    chk(r7_bad == 0, "R7 phases during ramp", r7_bad, 0);
    chk(r8_bad == 0, "R8 cpu toggle timing", r8_bad, 0);
    held = word;
    repeat (500) @(negedge clk);
    chk(word == held && r5_bad == 0, "R5 hold after ramp", word, held);
  endtask

  task automatic t_retarget();
    bit ok;
    logic [W-1:0] wmid;
    longint lim;
    int n;
    do_reset(7);
    set_sel(0);
    repeat (300) @(posedge clk);
    @(negedge clk); wmid = word;
    chk(longint'(wmid) < exp_word(7) && longint'(wmid) > exp_word(4),
        "R6 mid-ramp word", wmid, exp_word(7));
    set_sel(4);
    n = 0;
    while (word == wmid && n < 500) begin @(negedge clk); n++; end
    lim = longint'(wmid) >> 10;
    chk(word < wmid && longint'(wmid) - longint'(word) <= lim,
        "R6 continues from current word", word, wmid);
    wait_word(exp_word(4), 20000, ok);
    chk(ok, "R6 settles on new target", word, exp_word(4));
    chk(r3_bad + r4_bad + r7_bad + r8_bad == 0, "R4 retarget ramp clean",
        r3_bad + r4_bad + r7_bad + r8_bad, 0);
    set_sel(3);
    wait_word(exp_word(3), 20000, ok);
    chk(ok && r4_bad == 0, "R4 downward short ramp", word, exp_word(3));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    clear_counts();
    t_reset_table();
    t_settled();
    t_wide_ramp();
    t_retarget();
    if (!finished) finish_run();
  end

  initial begin
    #1900000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule